// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block sits on the device side of an asynchronous-style parallel flash bus, resampled on a core clock. It turns bus write cycles into commands: unlock-keyed programming, a fast programming mode that skips the unlock keys, chip-wide and sector erase, and an identification mode. The commands act on a small on-chip word array. Bus read cycles return array contents, identification codes, or a status byte while an operation runs. Busy times for programming, the sector-collection window and erase are parameters counted in core clock cycles.

An active-low hardware reset clears the state machine at once and aborts any operation in progress. A width select chooses between 16-bit word access and 8-bit byte-lane access.

The states are: ST_READ (array read), ST_UNL1 and ST_UNL2 (first and second unlock key seen), ST_PROG (waiting for program address/data), ST_ERS0, ST_ERS1 and ST_ERS2 (erase setup and its two re-keys), ST_EWIN (sector collection window), ST_AUTO (identification), ST_BYP (fast program mode), ST_BPROG (fast program data), ST_BEXIT (fast mode exit pending), ST_BUSYP (programming) and ST_BUSYE (erasing).

The transitions are:
- READ→UNL1 on key 1.
- UNL1→UNL2 on key 2.
- UNL2→PROG, ERS0, AUTO or BYP on command A0, 80, 90 or 20.
- ERS0→ERS1→ERS2 on the two keys.
- ERS2→BUSYE on 0x55/0x10.
- ERS2→EWIN on any address with 0x30.
- EWIN→EWIN on a further 0x30.
- EWIN→BUSYE when the window runs out.
- PROG→BUSYP on a write.
- BYP→BPROG on A0, and BPROG→BUSYP on a write.
- BYP→BEXIT on 90, and BEXIT→READ on 00 (any other value goes back to BYP).
- BUSYP→READ or BYP when programming finishes.
- BUSYE→READ when erasing finishes.
- AUTO→READ on F0.

Any other write in a keyed state goes to READ.

Top module: `nor_cmd_fsm`

## Requirements
- R1: A bus write is taken only in a cycle with ce_n=0, we_n=0 and oe_n=1. A sequence issued with oe_n=0 changes nothing.
- R2: A read cycle (ce_n=0, oe_n=0, we_n=1, rst_n=1) raises rdata_oe. In word mode and in ST_READ, rdata is the stored word at addr.
- R3: Writes 0x55/0xAA, 0xAA/0x55, 0x55/0xA0 and then address/data program one word. Programming only clears bits, so the result is old AND new.
- R4: While busy, reads return {8'h00, ~bit7 of the programmed data, toggle, 6'b0}, and the toggle bit inverts on every read. A program keeps busy high for exactly PROG_CYC cycles.
- R5: Keys, 0x55/0x80, keys, 0x55/0x10 sets every word to 0xFFFF. Status bit 7 reads 0 during the erase.
- R6: Keys, 0x55/0x80, keys, then 0x30 at any address in a sector selects that sector. Each further 0x30 within SECT_WIN cycles adds its sector. Only the selected sectors become 0xFFFF, where the sector is the top SECT_W bits of the word index.
- R7: Keys then 0x55/0x90 enter identification. A read with addr bit 0 = 0 gives MFR_ID and bit 0 = 1 gives DEV_ID, on bits 7:0. Writing 0xF0 returns to array reads.
- R8: Keys then 0x55/0x20 enter fast mode, where 0xA0 followed by address/data programs a word. The pair 0x90 then 0x00 leaves fast mode.
- R9: A wrong address/data pair inside a keyed sequence returns to ST_READ. Writing 0xF0 in any non-busy state returns to ST_READ, except in a program data cycle.
- R10: While rst_n is low, busy and rdata_oe are low. An erase in progress is abandoned without changing the array, and the block comes back in ST_READ.
- R11: With word_mode=0, the word index is addr>>1 and addr bit 0 picks the lane (0 low, 1 high). Reads return {8'h00, byte}, and a program changes only that lane using wdata[7:0].
- R12: Taking ce_n high during a program does not stop it. The program completes.
- R13: Writes during busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| word_mode | input | 1 | 1: 16-bit access, 0: byte-lane access |
| addr | input | ADDR_W | Bus address |
| wdata | input | 16 | Write data; commands use bits 7:0 |
| rdata | output | 16 | Read data |
| rdata_oe | output | 1 | Drive enable for rdata |
| busy | output | 1 | Collection window, program or erase in progress |

## Verification
The hardest case to reach is a multi-sector erase. It needs a second 0x30 write to land inside the collection window, and then the unselected sectors must be shown to keep their data. The stimulus first programs known zeros into several sectors through standard sequences. It then issues two sector commands on back-to-back bus writes and reads one word from each sector afterwards. A hardware reset is also driven in the middle of a chip erase, and words programmed earlier are read back to show that the erase never took effect.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    typedef enum logic [3:0] {
        ST_READ, ST_UNL1, ST_UNL2, ST_PROG,
        ST_ERS0, ST_ERS1, ST_ERS2, ST_EWIN,
        ST_AUTO, ST_BYP, ST_BPROG, ST_BEXIT,
        ST_BUSYP, ST_BUSYE
    } fsm_t;

    localparam logic [11:0] UNL_ADDR1 = 12'h555;
    localparam logic [11:0] UNL_ADDR2 = 12'h2AA;
    localparam logic [7:0]  KEY1      = 8'hAA;
    localparam logic [7:0]  KEY2      = 8'h55;
    localparam logic [7:0]  CMD_PROG  = 8'hA0;
    localparam logic [7:0]  CMD_ERASE = 8'h80;
    localparam logic [7:0]  CMD_IDENT = 8'h90;
    localparam logic [7:0]  CMD_BYP   = 8'h20;
    localparam logic [7:0]  CMD_CHIP  = 8'h10;
    localparam logic [7:0]  CMD_SECT  = 8'h30;
    localparam logic [7:0]  CMD_RESET = 8'hF0;
    localparam logic [7:0]  CMD_BEXIT = 8'h00;

endpackage

// File: rtl/nor_busy_timer.sv
module nor_busy_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] load,
    output logic         done
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cnt_q <= '0;
        else if (start)           cnt_q <= load;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign done = (cnt_q == W'(1));
endmodule

// File: rtl/nor_flash_array.sv
module nor_flash_array #(
    parameter int IDX_W  = 8,
    parameter int SECT_W = 2
) (
    input  logic                      clk,
    input  logic                      prog_en,
    input  logic [IDX_W-1:0]          prog_idx,
    input  logic [15:0]               prog_data,
    input  logic [15:0]               prog_mask,
    input  logic                      erase_en,
    input  logic [(1<<SECT_W)-1:0]    erase_sect,
    input  logic [IDX_W-1:0]          rd_idx,
    output logic [15:0]               rd_data
);
    localparam int DEPTH = 1 << IDX_W;

    logic [15:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        localparam logic [SECT_W-1:0] SEC = SECT_W'(g >> (IDX_W - SECT_W));
        logic [15:0] word_q;
        always_ff @(posedge clk) begin
            if (erase_en && erase_sect[SEC])
                word_q <= 16'hFFFF;
            else if (prog_en && prog_idx == IDX_W'(g))
                word_q <= word_q & (prog_data | ~prog_mask);
        end
        assign words[g] = word_q;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/nor_cmd_fsm.sv
module nor_cmd_fsm
    import nor_cmd_pkg::*;
#(
    parameter int          ADDR_W    = 8,
    parameter int          SECT_W    = 2,
    parameter int          PROG_CYC  = 8,
    parameter int          ERASE_CYC = 20,
    parameter int          SECT_WIN  = 6,
    parameter logic [7:0]  MFR_ID    = 8'h01,
    parameter logic [7:0]  DEV_ID    = 8'h3B
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              word_mode,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              rdata_oe,
    output logic              busy
);
    localparam int NSECT = 1 << SECT_W;
    localparam int TMAX  = PROG_CYC + ERASE_CYC + SECT_WIN;
    localparam int TW    = $clog2(TMAX + 1);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(UNL_ADDR1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(UNL_ADDR2);

    fsm_t state, nxt;

    logic              wr, rd, at1, at2;
    logic [7:0]        cmd;
    logic [ADDR_W-1:0] widx;
    logic              lane_hi;
    logic [NSECT-1:0]  sect_hot;

    logic              t_start, t_done;
    logic [TW-1:0]     t_load;
    logic              lat_prog, e_clr, e_add, e_all, op_prog, op_erase;

    logic [ADDR_W-1:0] p_idx;
    logic [15:0]       p_data, p_mask;
    logic [NSECT-1:0]  e_mask;
    logic              dq7_q, tog_q, ret_byp_q;
    logic [15:0]       arr_word;

    assign wr       = rst_n & ~ce_n & ~we_n & oe_n;
    assign rd       = rst_n & ~ce_n & ~oe_n & we_n;
    assign cmd      = wdata[7:0];
    assign at1      = (addr == A1) && (cmd == KEY1);
    assign at2      = (addr == A2) && (cmd == KEY2);
    assign widx     = word_mode ? addr : {1'b0, addr[ADDR_W-1:1]};
    assign lane_hi  = ~word_mode & addr[0];
    assign sect_hot = NSECT'(1) << widx[ADDR_W-1 -: SECT_W];

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_READ;
        else        state <= nxt;
    end

    // next state and control strobes
    always_comb begin
        nxt = state; t_start = 1'b0; t_load = '0;
        lat_prog = 1'b0; e_clr = 1'b0; e_add = 1'b0; e_all = 1'b0;
        op_prog = 1'b0; op_erase = 1'b0;
        unique case (state)
            ST_READ:  if (wr && at1) nxt = ST_UNL1;
            ST_UNL1:  if (wr) nxt = at2 ? ST_UNL2 : ST_READ;
            ST_UNL2:  if (wr) begin
                if (addr != A1)              nxt = ST_READ;
                else if (cmd == CMD_PROG)    nxt = ST_PROG;
                else if (cmd == CMD_ERASE)   nxt = ST_ERS0;
                else if (cmd == CMD_IDENT)   nxt = ST_AUTO;
                else if (cmd == CMD_BYP)     nxt = ST_BYP;
                else                         nxt = ST_READ;
            end
            ST_PROG, ST_BPROG: if (wr) begin
                lat_prog = 1'b1; t_start = 1'b1; t_load = TW'(PROG_CYC);
                nxt = ST_BUSYP;
            end
            ST_ERS0:  if (wr) nxt = at1 ? ST_ERS1 : ST_READ;
            ST_ERS1:  if (wr) nxt = at2 ? ST_ERS2 : ST_READ;
            ST_ERS2:  if (wr) begin
                if (addr == A1 && cmd == CMD_CHIP) begin
                    e_all = 1'b1; t_start = 1'b1; t_load = TW'(ERASE_CYC);
                    nxt = ST_BUSYE;
                end else if (cmd == CMD_SECT) begin
                    e_clr = 1'b1; t_start = 1'b1; t_load = TW'(SECT_WIN);
                    nxt = ST_EWIN;
                end else nxt = ST_READ;
            end
            ST_EWIN:  if (wr) begin
                if (cmd == CMD_SECT) begin
                    e_add = 1'b1; t_start = 1'b1; t_load = TW'(SECT_WIN);
                end else nxt = ST_READ;
            end else if (t_done) begin
                t_start = 1'b1; t_load = TW'(ERASE_CYC); nxt = ST_BUSYE;
            end
            ST_AUTO:  ;
            ST_BYP:   if (wr) begin
                if (cmd == CMD_PROG)       nxt = ST_BPROG;
                else if (cmd == CMD_IDENT) nxt = ST_BEXIT;
                else                       nxt = ST_READ;
            end
            ST_BEXIT: if (wr) nxt = (cmd == CMD_BEXIT) ? ST_READ : ST_BYP;
            ST_BUSYP: if (t_done) begin
                op_prog = 1'b1; nxt = ret_byp_q ? ST_BYP : ST_READ;
            end
            ST_BUSYE: if (t_done) begin
                op_erase = 1'b1; nxt = ST_READ;
            end
            default:  nxt = ST_READ;
        endcase
        if (wr && cmd == CMD_RESET &&
            !(state inside {ST_PROG, ST_BPROG, ST_EWIN, ST_BUSYP, ST_BUSYE}))
            nxt = ST_READ;
    end

    // latched operation data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            p_idx <= '0; p_data <= '0; p_mask <= '0; e_mask <= '0;
            dq7_q <= 1'b0; tog_q <= 1'b0; ret_byp_q <= 1'b0;
        end else begin
            if (lat_prog) begin
                p_idx     <= widx;
                p_mask    <= word_mode ? 16'hFFFF : (lane_hi ? 16'hFF00 : 16'h00FF);
                p_data    <= word_mode ? wdata :
                             (lane_hi ? {wdata[7:0], 8'h00} : {8'h00, wdata[7:0]});
                dq7_q     <= ~wdata[7];
                ret_byp_q <= (state == ST_BPROG);
            end
            if (e_all)      begin e_mask <= '1;                 dq7_q <= 1'b0; end
            else if (e_clr) begin e_mask <= sect_hot;           dq7_q <= 1'b0; end
            else if (e_add)       e_mask <= e_mask | sect_hot;
            if (busy && rd) tog_q <= ~tog_q;
        end
    end

    nor_flash_array #(.IDX_W(ADDR_W), .SECT_W(SECT_W)) u_array (
        .clk        (clk),
        .prog_en    (op_prog),
        .prog_idx   (p_idx),
        .prog_data  (p_data),
        .prog_mask  (p_mask),
        .erase_en   (op_erase),
        .erase_sect (e_mask),
        .rd_idx     (widx),
        .rd_data    (arr_word)
    );

    nor_busy_timer #(.W(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (t_start),
        .load  (t_load),
        .done  (t_done)
    );

    // outputs
    always_comb begin
        busy     = state inside {ST_EWIN, ST_BUSYP, ST_BUSYE};
        rdata_oe = rd;
        if (!rd)                   rdata = '0;
        else if (busy)             rdata = {8'h00, dq7_q, tog_q, 6'b0};
        else if (state == ST_AUTO) rdata = {8'h00, addr[0] ? DEV_ID : MFR_ID};
        else if (word_mode)        rdata = arr_word;
        else                       rdata = {8'h00, addr[0] ? arr_word[15:8] : arr_word[7:0]};
    end
endmodule

// File: rtl/nor_cmd_fsm_chk.sv
module nor_cmd_fsm_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic              word_mode,
    input logic [15:0]       rdata,
    input logic              rdata_oe,
    input logic              busy
);
    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!rdata_oe && !busy)); // R10

    AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_oe |-> (!ce_n && !oe_n && we_n)); // R2

    AST_STATUS_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rdata_oe) |-> (rdata[15:8] == 8'h00 && rdata[5:0] == 6'b0)); // R4

    AST_STATUS_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rdata_oe && $past(busy && rdata_oe)) |-> (rdata[6] != $past(rdata[6]))); // R4

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_mode && rdata_oe) |-> (rdata[15:8] == 8'h00)); // R11
endmodule

bind nor_cmd_fsm nor_cmd_fsm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .word_mode (word_mode),
    .rdata     (rdata),
    .rdata_oe  (rdata_oe),
    .busy      (busy)
);

// File: tb/nor_cmd_fsm_test.sv
module nor_cmd_fsm_test;
    localparam int PROG_CYC = 8;
    localparam logic [1:0] OW = 2'd0, ORD = 2'd1, ODL = 2'd2;
    localparam int NV = 85;

    // {op, addr, data/expected/cycles, requirement}
    localparam logic [29:0] VEC [NV] = '{
        {OW,8'h55,16'h00AA,4'd5}, {OW,8'hAA,16'h0055,4'd5}, {OW,8'h55,16'h0080,4'd5},
        {OW,8'h55,16'h00AA,4'd5}, {OW,8'hAA,16'h0055,4'd5}, {OW,8'h55,16'h0010,4'd5},
        {ODL,8'h00,16'd30,4'd0},
        {ORD,8'h10,16'hFFFF,4'd5}, {ORD,8'hC3,16'hFFFF,4'd5},            // R5 chip erase
        {OW,8'h55,16'h00AA,4'd3}, {OW,8'hAA,16'h0055,4'd3}, {OW,8'h55,16'h00A0,4'd3},
        {OW,8'h10,16'h1234,4'd3}, {ODL,8'h00,16'd12,4'd0},
        {ORD,8'h10,16'h1234,4'd3},                                        // R3 program
        {OW,8'h55,16'h00AA,4'd3}, {OW,8'hAA,16'h0055,4'd3}, {OW,8'h55,16'h00A0,4'd3},
        {OW,8'h10,16'hFF0F,4'd3}, {ODL,8'h00,16'd12,4'd0},
        {ORD,8'h10,16'h1204,4'd3},                                        // R3 only clears
        {OW,8'h55,16'h00AA,4'd7}, {OW,8'hAA,16'h0055,4'd7}, {OW,8'h55,16'h0090,4'd7},
        {ORD,8'h00,16'h0001,4'd7}, {ORD,8'h01,16'h003B,4'd7},            // R7 id codes
        {OW,8'h00,16'h00F0,4'd7}, {ORD,8'h10,16'h1204,4'd7},            // R7 exit
        {OW,8'h55,16'h00AA,4'd8}, {OW,8'hAA,16'h0055,4'd8}, {OW,8'h55,16'h0020,4'd8},
        {OW,8'h00,16'h00A0,4'd8}, {OW,8'h20,16'h5A5A,4'd8}, {ODL,8'h00,16'd12,4'd0},
        {OW,8'h00,16'h00A0,4'd8}, {OW,8'h21,16'h0F0F,4'd8}, {ODL,8'h00,16'd12,4'd0},
        {OW,8'h00,16'h0090,4'd8}, {OW,8'h00,16'h0000,4'd8},
        {ORD,8'h20,16'h5A5A,4'd8}, {ORD,8'h21,16'h0F0F,4'd8},            // R8 fast program
        {OW,8'h00,16'h00A0,4'd8}, {OW,8'h22,16'h0000,4'd8}, {ODL,8'h00,16'd12,4'd0},
        {ORD,8'h22,16'hFFFF,4'd8},                                        // R8 left fast mode
        {OW,8'h55,16'h00AA,4'd9}, {OW,8'hAA,16'h0054,4'd9}, {OW,8'h55,16'h00A0,4'd9},
        {OW,8'h23,16'h0000,4'd9}, {ODL,8'h00,16'd12,4'd0},
        {ORD,8'h23,16'hFFFF,4'd9},                                        // R9 bad key
        {OW,8'h55,16'h00AA,4'd9}, {OW,8'h00,16'h00F0,4'd9}, {OW,8'hAA,16'h0055,4'd9},
        {OW,8'h55,16'h00A0,4'd9}, {OW,8'h24,16'h0000,4'd9}, {ODL,8'h00,16'd12,4'd0},
        {ORD,8'h24,16'hFFFF,4'd9},                                        // R9 F0 reset
        {OW,8'h55,16'h00AA,4'd6}, {OW,8'hAA,16'h0055,4'd6}, {OW,8'h55,16'h00A0,4'd6},
        {OW,8'h40,16'h0000,4'd6}, {ODL,8'h00,16'd12,4'd0},
        {OW,8'h55,16'h00AA,4'd6}, {OW,8'hAA,16'h0055,4'd6}, {OW,8'h55,16'h00A0,4'd6},
        {OW,8'h80,16'h0000,4'd6}, {ODL,8'h00,16'd12,4'd0},
        {OW,8'h55,16'h00AA,4'd6}, {OW,8'hAA,16'h0055,4'd6}, {OW,8'h55,16'h00A0,4'd6},
        {OW,8'hC0,16'h0000,4'd6}, {ODL,8'h00,16'd12,4'd0},
        {OW,8'h55,16'h00AA,4'd6}, {OW,8'hAA,16'h0055,4'd6}, {OW,8'h55,16'h0080,4'd6},
        {OW,8'h55,16'h00AA,4'd6}, {OW,8'hAA,16'h0055,4'd6}, {OW,8'h40,16'h0030,4'd6},
        {OW,8'hC0,16'h0030,4'd6}, {ODL,8'h00,16'd40,4'd0},
        {ORD,8'h40,16'hFFFF,4'd6}, {ORD,8'hC0,16'hFFFF,4'd6},            // R6 chosen sectors
        {ORD,8'h80,16'h0000,4'd6}, {ORD,8'h10,16'h1204,4'd6}             // R6 others kept
    };

    logic        clk = 1'b0;
    logic        rst_n, ce_n, we_n, oe_n, word_mode;
    logic [7:0]  addr;
    logic [15:0] wdata, rdata;
    logic        rdata_oe, busy;
    int          errors = 0, checks = 0;
    bit          finished = 1'b0;

    always #5 clk = ~clk;

    nor_cmd_fsm uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .word_mode(word_mode), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rdata_oe(rdata_oe), .busy(busy)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input bit oe_lo = 1'b0);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0; oe_n = oe_lo ? 1'b0 : 1'b1;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] v);
        @(negedge clk);
        addr = a; ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1;
        #1 v = rdata;
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [15:0] exp, input string req);
        logic [15:0] v;
        rd(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic prog(input logic [7:0] a, input logic [15:0] d);
        wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(8'h55, 16'h00A0); wr(a, d);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [15:0] s1, s2;
        int n;
        rst_n = 1'b0; ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        word_mode = 1'b1; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        ce_n = 1'b0; oe_n = 1'b0;
        #1 chk(!rdata_oe && !busy, "R10 reset state", {14'b0, rdata_oe, busy}, 16'h0000);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [1:0]  op;
            logic [7:0]  a;
            logic [15:0] d;
            logic [3:0]  rq;
            {op, a, d, rq} = VEC[i];
            if (op == OW)       wr(a, d);
            else if (op == ODL) repeat (int'(d)) @(negedge clk);
            else begin
                rd(a, s1);
                chk(s1 == d, $sformatf("R%0d vector %0d", rq, i), s1, d);
            end
        end

        // R4 status format and toggle; R13 write while busy; R12 deselected busy
        prog(8'h30, 16'h7F00);
        chk(busy == 1'b1, "R4 busy after program", {15'b0, busy}, 16'h0001);
        rd(8'h30, s1);
        chk(s1[15:8] == 8'h00 && s1[7] == 1'b1 && s1[5:0] == 6'b0, "R4 status bits", s1, {8'h00, 2'b10, 6'b0});
        rd(8'h30, s2);
        chk(s2[6] != s1[6], "R4 toggle bit", s2, s1 ^ 16'h0040);
        wr(8'h31, 16'h0000);
        while (busy) @(negedge clk);
        rd_chk(8'h30, 16'h7F00, "R12 program completes while deselected");
        rd_chk(8'h31, 16'hFFFF, "R13 write during busy ignored");

        // R4 busy duration
        prog(8'h33, 16'h0000);
        n = 0;
        while (busy && n < 1000) begin @(negedge clk); n++; end
        chk(n == PROG_CYC, "R4 busy length", 16'(n), 16'(PROG_CYC));
        rd_chk(8'h33, 16'h0000, "R4 program result");

        // R1 writes with oe_n low are not writes
        wr(8'h55, 16'h00AA, 1'b1); wr(8'hAA, 16'h0055, 1'b1);
        wr(8'h55, 16'h00A0, 1'b1); wr(8'h32, 16'h0000, 1'b1);
        repeat (12) @(negedge clk);
        rd_chk(8'h32, 16'hFFFF, "R1 oe_n low blocks write");

        // R11 byte lanes
        word_mode = 1'b0;
        prog(8'h21, 16'h0002);
        repeat (12) @(negedge clk);
        rd_chk(8'h20, 16'h0004, "R11 low lane unchanged");
        rd_chk(8'h21, 16'h0002, "R11 high lane programmed");
        word_mode = 1'b1;
        rd_chk(8'h10, 16'h0204, "R11 word view");

        // R5 erase status, R10 reset aborts erase
        wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(8'h55, 16'h0080);
        wr(8'h55, 16'h00AA); wr(8'hAA, 16'h0055); wr(8'h55, 16'h0010);
        rd(8'h30, s1);
        chk(s1[7] == 1'b0 && busy, "R5 erase status bit7", s1, 16'h0000);
        @(negedge clk);
        rst_n = 1'b0; ce_n = 1'b0; oe_n = 1'b0;
        #1 chk(!rdata_oe && !busy, "R10 reset mid erase quiet", {14'b0, rdata_oe, busy}, 16'h0000);
        repeat (3) @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; rst_n = 1'b1;
        repeat (30) @(negedge clk);
        chk(!busy, "R10 idle after reset", {15'b0, busy}, 16'h0000);
        rd_chk(8'h30, 16'h7F00, "R10 erase abandoned");
        rd_chk(8'h33, 16'h0000, "R10 array read mode");

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule